// File: doc/BRIEF.md
# Backtracking Trail Unwind Engine

This block keeps the trail of a logic-programming engine: a stack in memory that records the address of every variable cell bound since the last choice point. A push request stores the address of a freshly bound cell in the next free trail slot and raises the trail pointer by one. When a goal fails, the caller presents the trail mark taken from the current choice point. The engine then walks the trail from the top down to that mark. It reads each recorded address and rewrites the cell it names as an unbound variable, which is a reference word that points to its own address. When the walk ends, the trail pointer equals the mark.

The engine owns a single-word memory port that has a fixed read latency of one cycle. Trail slot `i` lives at word address `TRAIL_BASE + i`. A busy flag, a one-cycle done pulse and a one-cycle error pulse report the progress of a failure request. Deciding when a binding has to be trailed, and building choice points, is left to the surrounding engine.

Top module: `trail_unwind_engine`

## Requirements
- R1: After reset the trail pointer is 0, `busy`, `done`, `err` and `push_ack` are low, and no memory request is issued.
- R2: While idle, not full and with no failure request, a push is acknowledged in the same cycle. It writes the zero-extended 28-bit cell address (bits 31:28 zero) to word `TRAIL_BASE + trail_ptr`, and the pointer rises by one at the next edge.
- R3: A failure request with a mark below the pointer rewrites every cell whose address sits in slots mark to pointer-1 with the word {2'b10, 1'b0 (cdr), 1'b0 (collect), cell address[27:0]}. Cells recorded below the mark are left untouched.
- R4: The walk runs from the highest slot down to the mark. Each entry takes exactly two cycles (slot read, then cell write), so an unwind of n entries ends 2n cycles after the request edge.
- R5: When the walk ends, the trail pointer equals the mark, `busy` is low, and `done` is high for exactly one cycle.
- R6: While `busy` is high, push requests are not acknowledged and write nothing.
- R7: When a push and a failure request arrive in the same idle cycle, the failure is taken and the push is refused.
- R8: A mark above the current pointer gives a one-cycle `err` pulse after the request edge. There is no memory access and the pointer does not change.
- R9: A mark equal to the pointer gives a one-cycle `done` pulse after the request edge, with no memory access.
- R10: When the pointer is at its maximum (all ones), pushes are refused.
- R11: A failure request that arrives while `busy` is high is ignored. The running walk ends at the mark it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Record a bound cell on the trail |
| push_addr | input | AW (28) | Address of the bound cell |
| push_ack | output | 1 | Push taken this cycle |
| fail_req | input | 1 | Start an unwind to `fail_mark` |
| fail_mark | input | TP_W (16) | Trail mark from the current choice point |
| busy | output | 1 | Unwind in progress |
| done | output | 1 | One-cycle pulse at the end of an unwind |
| err | output | 1 | One-cycle pulse for a mark above the pointer |
| trail_ptr | output | TP_W (16) | Current trail top |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (28) | Word address |
| mem_wdata | output | DW (32) | Write data |
| mem_rdata | input | DW (32) | Read data, valid the cycle after a read |

## Verification
A push and a failure request can both arrive in one idle cycle. This is the one place where the trail's two functions contend for the pointer and the memory port. The bench drives both on the same clock low phase and checks that `push_ack` stays low. It then checks that the following walk removes exactly the entries that existed before that cycle. A second overlap comes from pushes and repeated failure requests presented in the middle of a walk. The log of memory writes and the final pointer must show that neither was taken.

// File: rtl/trail_pkg.sv
package trail_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_UNDO = 2'd2
    } walk_state_e;

    // tag of a reference word in the two top bits
    localparam logic [1:0] REF_TAG = 2'b10;

endpackage

// File: rtl/trail_slot_addr.sv
module trail_slot_addr #(
    parameter int          AW         = 28,
    parameter int          TP_W       = 16,
    parameter logic [27:0] TRAIL_BASE = 28'h000_0200
) (
    input  logic [TP_W-1:0] slot_idx,
    output logic [AW-1:0]   slot_addr
);
    localparam int EXT_W = AW - TP_W;

    logic [AW-1:0] idx_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign idx_ext = {{EXT_W{1'b0}}, slot_idx};
        end else begin : g_same
            assign idx_ext = slot_idx[AW-1:0];
        end
    endgenerate

    assign slot_addr = TRAIL_BASE[AW-1:0] + idx_ext;

endmodule

// File: rtl/unbound_word_former.sv
module unbound_word_former #(
    parameter int AW = 28,
    parameter int DW = 32
) (
    input  logic [AW-1:0] cell_ref,
    output logic [DW-1:0] unbound_word
);
    import trail_pkg::*;

    localparam int PAD_W = DW - AW - 4;

    generate
        if (PAD_W > 0) begin : g_pad
            assign unbound_word = {REF_TAG, 1'b0, 1'b0, {PAD_W{1'b0}}, cell_ref};
        end else begin : g_tight
            assign unbound_word = {REF_TAG, 1'b0, 1'b0, cell_ref};
        end
    endgenerate

endmodule

// File: rtl/trail_unwind_ctrl.sv
module trail_unwind_ctrl #(
    parameter int AW   = 28,
    parameter int DW   = 32,
    parameter int TP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_req,
    input  logic [AW-1:0]   push_addr,
    input  logic            fail_req,
    input  logic [TP_W-1:0] fail_mark,
    input  logic [AW-1:0]   slot_addr,
    input  logic [AW-1:0]   cell_addr,
    input  logic [DW-1:0]   unbound_word,
    output logic [TP_W-1:0] slot_idx,
    output logic            push_ack,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [TP_W-1:0] trail_ptr,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata
);
    import trail_pkg::*;

    localparam logic [TP_W-1:0] TP_MAX = '1;
    localparam logic [TP_W-1:0] TP_ONE = {{(TP_W-1){1'b0}}, 1'b1};
    localparam int              ZX_W   = DW - AW;

    typedef struct packed {
        walk_state_e     state;
        logic [TP_W-1:0] tp;
        logic [TP_W-1:0] mark;
        logic            done;
        logic            err;
    } ctrl_t;

    ctrl_t cs_q, cs_d;
    logic [TP_W-1:0] tp_below;
    logic            last_entry;

    assign tp_below   = cs_q.tp - TP_ONE;
    assign last_entry = (tp_below == cs_q.mark);

    always_comb begin
        cs_d      = cs_q;
        cs_d.done = 1'b0;
        cs_d.err  = 1'b0;
        push_ack  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        slot_idx  = cs_q.tp;
        case (cs_q.state)
            ST_IDLE: begin
                if (fail_req) begin
                    if (fail_mark > cs_q.tp) begin
                        cs_d.err = 1'b1;
                    end else if (fail_mark == cs_q.tp) begin
                        cs_d.done = 1'b1;
                    end else begin
                        cs_d.mark  = fail_mark;
                        cs_d.state = ST_READ;
                    end
                end else if (push_req && (cs_q.tp != TP_MAX)) begin
                    push_ack  = 1'b1;
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = slot_addr;
                    mem_wdata = {{ZX_W{1'b0}}, push_addr};
                    cs_d.tp   = cs_q.tp + TP_ONE;
                end
            end
            ST_READ: begin
                slot_idx   = tp_below;
                mem_req    = 1'b1;
                mem_addr   = slot_addr;
                cs_d.state = ST_UNDO;
            end
            ST_UNDO: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                mem_addr   = cell_addr;
                mem_wdata  = unbound_word;
                cs_d.tp    = tp_below;
                cs_d.state = last_entry ? ST_IDLE : ST_READ;
                cs_d.done  = last_entry;
            end
            default: begin
                cs_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= '{state: ST_IDLE, tp: '0, mark: '0, done: 1'b0, err: 1'b0};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign busy      = (cs_q.state != ST_IDLE);
    assign done      = cs_q.done;
    assign err       = cs_q.err;
    assign trail_ptr = cs_q.tp;

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        push_ack |=> (trail_ptr == $past(trail_ptr) + TP_ONE)); // R2
    AST_BUSY_ABOVE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (trail_ptr > cs_q.mark)); // R3
    AST_UNDO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we) |=> (trail_ptr == $past(trail_ptr) - TP_ONE)); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R5
    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !push_ack); // R6
    AST_BAD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_req && !busy && (fail_mark > trail_ptr)) |=> (err && !busy && $stable(trail_ptr))); // R8
    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_ptr == TP_MAX) |-> !push_ack); // R10

endmodule

// File: rtl/trail_unwind_engine.sv
module trail_unwind_engine #(
    parameter int          AW         = 28,
    parameter int          DW         = 32,
    parameter int          TP_W       = 16,
    parameter logic [27:0] TRAIL_BASE = 28'h000_0200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_req,
    input  logic [AW-1:0]   push_addr,
    output logic            push_ack,
    input  logic            fail_req,
    input  logic [TP_W-1:0] fail_mark,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [TP_W-1:0] trail_ptr,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);
    logic [TP_W-1:0] slot_idx;
    logic [AW-1:0]   slot_addr;
    logic [DW-1:0]   unbound_word;

    trail_slot_addr #(
        .AW(AW), .TP_W(TP_W), .TRAIL_BASE(TRAIL_BASE)
    ) u_slot (
        .slot_idx (slot_idx),
        .slot_addr(slot_addr)
    );

    unbound_word_former #(
        .AW(AW), .DW(DW)
    ) u_former (
        .cell_ref    (mem_rdata[AW-1:0]),
        .unbound_word(unbound_word)
    );

    trail_unwind_ctrl #(
        .AW(AW), .DW(DW), .TP_W(TP_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_req    (push_req),
        .push_addr   (push_addr),
        .fail_req    (fail_req),
        .fail_mark   (fail_mark),
        .slot_addr   (slot_addr),
        .cell_addr   (mem_rdata[AW-1:0]),
        .unbound_word(unbound_word),
        .slot_idx    (slot_idx),
        .push_ack    (push_ack),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .trail_ptr   (trail_ptr),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata)
    );

    // trail entries hold zero-extended cell addresses
    AST_ENTRY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_we) |-> (mem_rdata[DW-1:AW] == '0)); // R2

endmodule

// File: tb/test_trail_unwind_engine.sv
module test_trail_unwind_engine;

    localparam int AW   = 28;
    localparam int DW   = 32;
    localparam int TP_W = 16;
    localparam logic [27:0] BASE = 28'h000_0200;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            push_req = 1'b0;
    logic [AW-1:0]   push_addr = '0;
    logic            push_ack;
    logic            fail_req = 1'b0;
    logic [TP_W-1:0] fail_mark = '0;
    logic            busy, done, err;
    logic [TP_W-1:0] trail_ptr;
    logic            mem_req, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic [DW-1:0]   mem_rdata = '0;

    logic [31:0] mem [0:1023];
    int          acc_n;
    int          wr_n;
    logic [AW-1:0] wlog [0:63];
    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    trail_unwind_engine #(.AW(AW), .DW(DW), .TP_W(TP_W), .TRAIL_BASE(BASE)) i_trail_unwind_engine (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_addr(push_addr), .push_ack(push_ack),
        .fail_req(fail_req), .fail_mark(fail_mark), .busy(busy), .done(done), .err(err),
        .trail_ptr(trail_ptr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            acc_n = acc_n + 1;
            if (mem_we) begin
                mem[mem_addr[9:0]] <= mem_wdata;
                if (wr_n < 64) wlog[wr_n] = mem_addr;
                wr_n = wr_n + 1;
            end else begin
                mem_rdata <= mem[mem_addr[9:0]];
            end
        end
    end

    function automatic logic [31:0] bound_val(input int i);
        return 32'h5A00_0000 + i;
    endfunction

    function automatic logic [31:0] unbound_val(input int a);
        return {2'b10, 2'b00, 28'(a)};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_log();
        acc_n = 0;
        wr_n  = 0;
    endtask

    task automatic do_push(input int a, input string req);
        logic [TP_W-1:0] tp0;
        tp0 = trail_ptr;
        push_req  = 1'b1;
        push_addr = AW'(a);
        #1;
        chk(req, "push_ack", 32'(push_ack), 32'd1);
        tick();
        push_req = 1'b0;
        chk(req, "ptr after push", 32'(trail_ptr), 32'(tp0) + 1);
        chk(req, "slot content", mem[10'(BASE) + 10'(tp0)], 32'(a));
    endtask

    // waits for done, returns cycles after the request edge
    task automatic wait_done(output int k);
        k = 0;
        while (!done && k < 100) begin
            tick();
            k++;
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < 1024; i++) mem[i] = bound_val(i);
        rst_n = 1'b0;
        repeat (3) tick();
        clear_log();
        rst_n = 1'b1;
        #1;
        chk("R1", "ptr", 32'(trail_ptr), 32'd0);
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "done/err", {30'd0, done, err}, 32'd0);
        chk("R1", "push_ack", 32'(push_ack), 32'd0);
        tick();
        chk("R1", "no mem access", 32'(acc_n), 32'd0);
    endtask

    task automatic t_push_basic();
        for (int i = 0; i < 5; i++) do_push(16'h10 + i, "R2");
    endtask

    // unwind 5->2 with a push attempted mid-walk
    task automatic t_unwind_partial();
        int k;
        clear_log();
        fail_req  = 1'b1;
        fail_mark = 16'd2;
        tick();
        fail_req = 1'b0;
        chk("R4", "busy after request", 32'(busy), 32'd1);
        push_req  = 1'b1;
        push_addr = 28'h0AB;
        #1;
        chk("R6", "push_ack while busy", 32'(push_ack), 32'd0);
        tick();
        push_req = 1'b0;
        wait_done(k);
        k = k + 1;
        chk("R4", "walk cycles", 32'(k), 32'd6);
        chk("R5", "done", 32'(done), 32'd1);
        chk("R5", "busy at done", 32'(busy), 32'd0);
        chk("R5", "ptr at mark", 32'(trail_ptr), 32'd2);
        chk("R6", "writes during walk", 32'(wr_n), 32'd3);
        for (int j = 0; j < 3; j++)
            chk("R4", "write order", 32'(wlog[j]), 32'(16'h14 - j));
        for (int j = 2; j < 5; j++)
            chk("R3", "cell reset", mem[16'h10 + j], unbound_val(16'h10 + j));
        chk("R3", "cell below mark", mem[16'h10], bound_val(16'h10));
        chk("R3", "cell below mark", mem[16'h11], bound_val(16'h11));
        chk("R6", "ignored push cell", mem[16'h0AB], bound_val(16'h0AB));
        tick();
        chk("R5", "done one cycle", 32'(done), 32'd0);
    endtask

    task automatic t_empty();
        clear_log();
        fail_req  = 1'b1;
        fail_mark = 16'd2;
        tick();
        fail_req = 1'b0;
        chk("R9", "done", 32'(done), 32'd1);
        chk("R9", "busy", 32'(busy), 32'd0);
        tick();
        chk("R9", "done one cycle", 32'(done), 32'd0);
        chk("R9", "no mem access", 32'(acc_n), 32'd0);
        chk("R9", "ptr", 32'(trail_ptr), 32'd2);
    endtask

    task automatic t_bad_mark();
        clear_log();
        fail_req  = 1'b1;
        fail_mark = 16'd5;
        tick();
        fail_req = 1'b0;
        chk("R8", "err", 32'(err), 32'd1);
        chk("R8", "busy", 32'(busy), 32'd0);
        chk("R8", "done", 32'(done), 32'd0);
        tick();
        chk("R8", "err one cycle", 32'(err), 32'd0);
        chk("R8", "no mem access", 32'(acc_n), 32'd0);
        chk("R8", "ptr unchanged", 32'(trail_ptr), 32'd2);
    endtask

    task automatic t_collide();
        int k;
        clear_log();
        fail_req  = 1'b1;
        fail_mark = 16'd0;
        push_req  = 1'b1;
        push_addr = 28'h0CD;
        #1;
        chk("R7", "push refused on collision", 32'(push_ack), 32'd0);
        tick();
        fail_req = 1'b0;
        push_req = 1'b0;
        wait_done(k);
        chk("R7", "walk cycles", 32'(k), 32'd4);
        chk("R7", "ptr", 32'(trail_ptr), 32'd0);
        chk("R7", "writes", 32'(wr_n), 32'd2);
        chk("R7", "cell 0x11", mem[16'h11], unbound_val(16'h11));
        chk("R7", "cell 0x10", mem[16'h10], unbound_val(16'h10));
        chk("R7", "pushed cell untouched", mem[16'h0CD], bound_val(16'h0CD));
        tick();
    endtask

    task automatic t_fail_while_busy();
        int k;
        for (int i = 0; i < 4; i++) do_push(16'h20 + i, "R2");
        clear_log();
        fail_req  = 1'b1;
        fail_mark = 16'd1;
        tick();
        fail_mark = 16'd3;
        tick();
        tick();
        fail_req = 1'b0;
        wait_done(k);
        k = k + 2;
        chk("R11", "walk cycles", 32'(k), 32'd6);
        chk("R11", "ptr at first mark", 32'(trail_ptr), 32'd1);
        chk("R11", "writes", 32'(wr_n), 32'd3);
        chk("R11", "cell 0x21", mem[16'h21], unbound_val(16'h21));
        chk("R11", "cell 0x20", mem[16'h20], bound_val(16'h20));
        tick();
    endtask

    task automatic t_full();
        int acks;
        acks = 0;
        push_req  = 1'b1;
        push_addr = 28'h3F0;
        for (int i = 0; i < 65540; i++) begin
            #1;
            if (push_ack) acks++;
            tick();
        end
        #1;
        chk("R10", "ptr at max", 32'(trail_ptr), 32'h0000_FFFF);
        chk("R10", "push refused when full", 32'(push_ack), 32'd0);
        chk("R10", "accepted pushes", 32'(acks), 32'd65534);
        push_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        acc_n = 0;
        wr_n  = 0;
        @(negedge clk);
        t_reset();
        t_push_basic();
        t_unwind_partial();
        t_empty();
        t_bad_mark();
        t_collide();
        t_fail_while_busy();
        t_full();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule